// File: doc/BRIEF.md
# USB Endpoint Receive Status Tracker

This block follows the receive side of one USB device endpoint, which may be a control endpoint or an OUT endpoint. A serial interface engine feeds it decoded events: a token strobe with its kind, an end-of-packet strobe, and the error flags for that packet. The tracker decides whether the packet earns an ACK. It records the outcome in a five-bit status register that firmware can read, keeps the receive data toggle, and raises a sticky receive interrupt flag.

After a SETUP packet has been accepted on a control endpoint, the block freezes the endpoint's FIFO read state. The freeze lasts until firmware releases it, so a firmware read that is still in progress cannot disturb the newly written setup data. On isochronous endpoints the outcome is not posted when the packet ends. It is held in a pending slot and posted at the next start-of-frame token.

Top module: `ep_rx_tracker`

## Requirements
- R1: After reset, `regRdData` is 0, `rxToggle` is 0, `rxIrq` is 0, `hsAck` is 0 and `fifoFreeze` is 0.
- R2: `regRdData` bits are: [4] freeze lock, [3] toggle-load enable (always reads 0), [2] void, [1] error, [0] acknowledged. The error and acknowledged bits are never both 1.
- R3: On a non-isochronous endpoint, a transaction (OUT token `tokKind`=00 or SETUP token `tokKind`=01, then `pktEnd`) with no error, no lock and no stall sets the status to ack=1, error=0, void=0. `hsAck` pulses for one cycle after the `pktEnd` edge, `rxToggle` flips and `rxIrq` sets.
- R4: If any of `crcErr`, `stuffErr`, `fifoOvr` or `fifoUnd` is high at `pktEnd`, the status becomes error=1, ack=0, void=0. No `hsAck` is sent, `rxToggle` is unchanged and `rxIrq` sets.
- R5: If the lock bit or `cfgStall` is set when the transaction ends, the void bit sets. The error bit, the ack bit, `rxIrq` and `rxToggle` are unchanged, and no `hsAck` is sent.
- R6: A SETUP token forces `rxToggle` to 0 on its own edge. An accepted (non-void) SETUP sets the lock bit and `fifoFreeze` only when `cfgCtrl` is 1.
- R7: Firmware writes (`regWrEn`) with bit 4 set clear the lock. Writing 0 to bit 4 leaves the lock unchanged. A hardware lock set in the same cycle as a clear wins.
- R8: A write with bit 3 set loads `rxToggle` from `seqWrVal`. With bit 3 at 0 the toggle is unchanged. The load wins over a same-cycle hardware flip.
- R9: When `cfgIso` is 1, the end of a packet leaves the status and `rxToggle` unchanged and sends no `hsAck`. The outcome is posted at the next SOF token (`tokKind`=10).
- R10: A newer isochronous outcome replaces an unposted one. An SOF token with nothing pending changes nothing.
- R11: `rxIrq` stays set until an `irqClr` pulse. A same-cycle set wins over `irqClr`.
- R12: A `pktEnd` with no SETUP or OUT token before it is ignored. `tokKind`=11 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tokValid | input | 1 | Token strobe |
| tokKind | input | 2 | 00 OUT, 01 SETUP, 10 SOF, 11 ignored |
| pktEnd | input | 1 | End of data packet strobe |
| crcErr | input | 1 | CRC failure, valid with pktEnd |
| stuffErr | input | 1 | Bit-stuffing failure, valid with pktEnd |
| fifoOvr | input | 1 | FIFO overrun during reception |
| fifoUnd | input | 1 | FIFO underrun during reception |
| cfgStall | input | 1 | Endpoint is stalled |
| cfgIso | input | 1 | Endpoint is isochronous |
| cfgCtrl | input | 1 | Endpoint is a control endpoint |
| regWrEn | input | 1 | Firmware write strobe |
| regWrData | input | 5 | Firmware write data |
| seqWrVal | input | 1 | Toggle value loaded when bit 3 is written as 1 |
| irqClr | input | 1 | Clears the receive interrupt flag |
| regRdData | output | 5 | Status register read value |
| rxToggle | output | 1 | Expected receive data toggle |
| rxIrq | output | 1 | Receive interrupt flag |
| hsAck | output | 1 | Send ACK handshake pulse |
| fifoFreeze | output | 1 | FIFO read state frozen |

## Verification
Two pairs of events can collide in one cycle. The first is a firmware write that releases the lock landing on the same edge as the completion of an accepted SETUP. The second is a firmware toggle load landing on the same edge as an ACK flip. The bench drives both events in a single cycle. It expects the lock to stay set in the first case and the loaded toggle value to hold in the second. A behavioural reference model is compared against every output on every clock. Directed checks also cover an SOF token that posts a pending isochronous outcome while a newer one replaces it.

// File: rtl/ep_rx_pkg.sv
package ep_rx_pkg;
  localparam int STAT_W = 5;
  localparam int LOCK_B = 4;
  localparam int SEQ_B  = 3;
  localparam int VOID_B = 2;
  localparam int ERR_B  = 1;
  localparam int ACK_B  = 0;
  localparam int KIND_W = 2;

  typedef enum logic [KIND_W-1:0] {
    TOK_OUT   = 2'b00,
    TOK_SETUP = 2'b01,
    TOK_SOF   = 2'b10,
    TOK_RSVD  = 2'b11
  } tokKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic forceTog0;
    logic commitNow;
    logic pendWr;
    logic sofTick;
    logic setLock;
    logic sendAck;
    logic rVoid;
    logic rErr;
    logic rAck;
  } rxStrobe_t;
endpackage

// File: rtl/ep_rx_ctrl.sv
module ep_rx_ctrl
  import ep_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tokValid,
  input  logic [KIND_W-1:0] tokKind,
  input  logic              pktEnd,
  input  logic              crcErr,
  input  logic              stuffErr,
  input  logic              fifoOvr,
  input  logic              fifoUnd,
  input  logic              cfgStall,
  input  logic              cfgIso,
  input  logic              cfgCtrl,
  input  logic              lockNow,
  output rxStrobe_t         strb
);
  logic inXfer;
  logic xferSetup;
  logic isOut, isSetup, isSof;
  logic done, isVoid, anyErr;

  always_comb begin
    isOut   = tokValid && (tokKind == TOK_OUT);
    isSetup = tokValid && (tokKind == TOK_SETUP);
    isSof   = tokValid && (tokKind == TOK_SOF);
  end

  // open transaction tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inXfer    <= 1'b0;
      xferSetup <= 1'b0;
    end else if (isOut || isSetup) begin
      inXfer    <= 1'b1;
      xferSetup <= isSetup;
    end else if (pktEnd) begin
      inXfer    <= 1'b0;
    end
  end

  always_comb begin
    done   = pktEnd && inXfer;
    isVoid = lockNow || cfgStall;
    anyErr = crcErr || stuffErr || fifoOvr || fifoUnd;

    strb.rVoid     = isVoid;
    strb.rErr      = !isVoid && anyErr;
    strb.rAck      = !isVoid && !anyErr;
    strb.commitNow = done && !cfgIso;
    strb.pendWr    = done && cfgIso;
    strb.sofTick   = isSof;
    strb.forceTog0 = isSetup;
    strb.setLock   = done && xferSetup && !isVoid && cfgCtrl;
    strb.sendAck   = done && !cfgIso && !isVoid && !anyErr;
  end
endmodule

// File: rtl/ep_rx_dp.sv
module ep_rx_dp
  import ep_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strb,
  input  logic              regWrEn,
  input  logic [STAT_W-1:0] regWrData,
  input  logic              seqWrVal,
  input  logic              irqClr,
  output logic [STAT_W-1:0] regRdData,
  output logic              rxToggle,
  output logic              rxIrq,
  output logic              hsAck,
  output logic              lockNow
);
  logic lockQ, voidQ, errQ, ackQ, togQ, irqQ, hsAckQ;
  logic pendValid, pendVoid, pendErr, pendAck;
  logic selUpd, selVoid, selErr, selAck;
  logic fwLoad, fwClr;

  always_comb begin
    fwLoad = regWrEn && regWrData[SEQ_B];
    fwClr  = regWrEn && regWrData[LOCK_B];
    if (strb.commitNow) begin
      selUpd  = 1'b1;
      selVoid = strb.rVoid;
      selErr  = strb.rErr;
      selAck  = strb.rAck;
    end else begin
      selUpd  = strb.sofTick && pendValid;
      selVoid = pendVoid;
      selErr  = pendErr;
      selAck  = pendAck;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockQ <= 1'b0;
      voidQ <= 1'b0;
      errQ  <= 1'b0;
      ackQ  <= 1'b0;
      togQ  <= 1'b0;
      irqQ  <= 1'b0;
      hsAckQ <= 1'b0;
      pendValid <= 1'b0;
      pendVoid  <= 1'b0;
      pendErr   <= 1'b0;
      pendAck   <= 1'b0;
    end else begin
      hsAckQ <= strb.sendAck;

      if (strb.setLock)  lockQ <= 1'b1;
      else if (fwClr)    lockQ <= 1'b0;

      if (fwLoad)              togQ <= seqWrVal;
      else if (strb.forceTog0) togQ <= 1'b0;
      else if (strb.sendAck)   togQ <= ~togQ;

      if (strb.pendWr) begin
        pendValid <= 1'b1;
        pendVoid  <= strb.rVoid;
        pendErr   <= strb.rErr;
        pendAck   <= strb.rAck;
      end else if (strb.sofTick) begin
        pendValid <= 1'b0;
      end

      if (selUpd) begin
        if (selVoid) begin
          voidQ <= 1'b1;
        end else begin
          voidQ <= 1'b0;
          errQ  <= selErr;
          ackQ  <= selAck;
        end
      end

      if (selUpd && !selVoid) irqQ <= 1'b1;
      else if (irqClr)        irqQ <= 1'b0;
    end
  end

  always_comb begin
    regRdData         = '0;
    regRdData[LOCK_B] = lockQ;
    regRdData[VOID_B] = voidQ;
    regRdData[ERR_B]  = errQ;
    regRdData[ACK_B]  = ackQ;
    rxToggle = togQ;
    rxIrq    = irqQ;
    hsAck    = hsAckQ;
    lockNow  = lockQ;
  end
endmodule

// File: rtl/ep_rx_tracker.sv
module ep_rx_tracker
  import ep_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tokValid,
  input  logic [KIND_W-1:0] tokKind,
  input  logic              pktEnd,
  input  logic              crcErr,
  input  logic              stuffErr,
  input  logic              fifoOvr,
  input  logic              fifoUnd,
  input  logic              cfgStall,
  input  logic              cfgIso,
  input  logic              cfgCtrl,
  input  logic              regWrEn,
  input  logic [STAT_W-1:0] regWrData,
  input  logic              seqWrVal,
  input  logic              irqClr,
  output logic [STAT_W-1:0] regRdData,
  output logic              rxToggle,
  output logic              rxIrq,
  output logic              hsAck,
  output logic              fifoFreeze
);
  rxStrobe_t strb;
  logic lockNow;

  ep_rx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tokValid(tokValid), .tokKind(tokKind),
    .pktEnd(pktEnd), .crcErr(crcErr), .stuffErr(stuffErr),
    .fifoOvr(fifoOvr), .fifoUnd(fifoUnd), .cfgStall(cfgStall),
    .cfgIso(cfgIso), .cfgCtrl(cfgCtrl), .lockNow(lockNow), .strb(strb)
  );

  ep_rx_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regWrEn(regWrEn),
    .regWrData(regWrData), .seqWrVal(seqWrVal), .irqClr(irqClr),
    .regRdData(regRdData), .rxToggle(rxToggle), .rxIrq(rxIrq),
    .hsAck(hsAck), .lockNow(lockNow)
  );

  assign fifoFreeze = lockNow;
endmodule

// File: rtl/ep_rx_tracker_chk.sv
module ep_rx_tracker_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cfgIso,
  input logic       cfgCtrl,
  input logic       regWrEn,
  input logic [4:0] regWrData,
  input logic [4:0] regRdData,
  input logic       rxToggle,
  input logic       rxIrq,
  input logic       hsAck,
  input logic       fifoFreeze
);
  a_r2_err_ack_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(regRdData[1] && regRdData[0]));

  a_r3_ack_status: assert property (@(posedge clk) disable iff (!rstN)
    hsAck |-> (regRdData[0] && !regRdData[2]));

  a_r3_ack_flip: assert property (@(posedge clk) disable iff (!rstN)
    (hsAck && !$past(regWrEn && regWrData[3])) |-> (rxToggle != $past(rxToggle)));

  a_r5_void_keeps: assert property (@(posedge clk) disable iff (!rstN)
    $rose(regRdData[2]) |-> (regRdData[1:0] == $past(regRdData[1:0])));

  a_r6_lock_ctrl_only: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fifoFreeze) |-> $past(cfgCtrl));

  a_r9_iso_no_ack: assert property (@(posedge clk) disable iff (!rstN)
    hsAck |-> !$past(cfgIso));

  a_r11_irq_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxIrq) |-> (regRdData[1] || regRdData[0]));
endmodule

bind ep_rx_tracker ep_rx_tracker_chk u_chk (
  .clk(clk), .rstN(rstN), .cfgIso(cfgIso), .cfgCtrl(cfgCtrl),
  .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
  .rxToggle(rxToggle), .rxIrq(rxIrq), .hsAck(hsAck), .fifoFreeze(fifoFreeze)
);

// File: tb/ep_rx_tracker_tb.sv
`timescale 1ns/1ps
module ep_rx_tracker_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tokValid = 0, pktEnd = 0, crcErr = 0, stuffErr = 0, fifoOvr = 0, fifoUnd = 0;
  logic [1:0] tokKind = 2'b00;
  logic cfgStall = 0, cfgIso = 0, cfgCtrl = 0;
  logic regWrEn = 0, seqWrVal = 0, irqClr = 0;
  logic [4:0] regWrData = '0;
  logic [4:0] regRdData;
  logic rxToggle, rxIrq, hsAck, fifoFreeze;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";

  always #10 clk = ~clk;

  ep_rx_tracker u_dut (
    .clk(clk), .rstN(rstN), .tokValid(tokValid), .tokKind(tokKind),
    .pktEnd(pktEnd), .crcErr(crcErr), .stuffErr(stuffErr), .fifoOvr(fifoOvr),
    .fifoUnd(fifoUnd), .cfgStall(cfgStall), .cfgIso(cfgIso), .cfgCtrl(cfgCtrl),
    .regWrEn(regWrEn), .regWrData(regWrData), .seqWrVal(seqWrVal), .irqClr(irqClr),
    .regRdData(regRdData), .rxToggle(rxToggle), .rxIrq(rxIrq), .hsAck(hsAck),
    .fifoFreeze(fifoFreeze)
  );

  // behavioural reference model
  bit mOpen, mSetup, mLock, mVoid, mErr, mAck, mTog, mIrq, mHs;
  bit pValid, pVoid, pErr, pAck;

  always @(posedge clk) begin
    if (!rstN) begin
      mOpen = 0; mSetup = 0; mLock = 0; mVoid = 0; mErr = 0; mAck = 0;
      mTog = 0; mIrq = 0; mHs = 0; pValid = 0; pVoid = 0; pErr = 0; pAck = 0;
    end else begin
      bit finished, voided, bad, good, sof, post, nLock, nTog, nIrq;
      bit uV, uE, uA;
      finished = pktEnd && mOpen;
      voided = mLock || cfgStall;
      bad = crcErr || stuffErr || fifoOvr || fifoUnd;
      good = !voided && !bad;
      sof = tokValid && tokKind == 2'b10;
      nLock = mLock; nTog = mTog; nIrq = mIrq;
      if (regWrEn && regWrData[4]) nLock = 0;
      if (finished && mSetup && !voided && cfgCtrl) nLock = 1;
      if (tokValid && tokKind == 2'b01) nTog = 0;
      else if (finished && !cfgIso && good) nTog = !mTog;
      if (regWrEn && regWrData[3]) nTog = seqWrVal;
      mHs = finished && !cfgIso && good;
      post = 0; uV = 0; uE = 0; uA = 0;
      if (finished && !cfgIso) begin
        post = 1; uV = voided; uE = !voided && bad; uA = good;
      end else if (sof && pValid) begin
        post = 1; uV = pVoid; uE = pErr; uA = pAck;
      end
      if (irqClr) nIrq = 0;
      if (post && !uV) nIrq = 1;
      if (post) begin
        if (uV) mVoid = 1;
        else begin mVoid = 0; mErr = uE; mAck = uA; end
      end
      if (finished && cfgIso) begin
        pValid = 1; pVoid = voided; pErr = !voided && bad; pAck = good;
      end else if (sof) pValid = 0;
      if (tokValid && (tokKind == 2'b00 || tokKind == 2'b01)) begin
        mOpen = 1; mSetup = (tokKind == 2'b01);
      end else if (pktEnd) mOpen = 0;
      mLock = nLock; mTog = nTog; mIrq = nIrq;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      checks++;
      if (regRdData !== {mLock, 1'b0, mVoid, mErr, mAck} || rxToggle !== mTog ||
          rxIrq !== mIrq || hsAck !== mHs || fifoFreeze !== mLock) begin
        errors++;
        $display("FAIL %s model: act rd=%b tog=%b irq=%b hs=%b frz=%b exp rd=%b tog=%b irq=%b hs=%b frz=%b",
                 curReq, regRdData, rxToggle, rxIrq, hsAck, fifoFreeze,
                 {mLock, 1'b0, mVoid, mErr, mAck}, mTog, mIrq, mHs, mLock);
      end
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    tokValid = 0; pktEnd = 0; crcErr = 0; stuffErr = 0; fifoOvr = 0; fifoUnd = 0;
    regWrEn = 0; regWrData = '0; seqWrVal = 0; irqClr = 0;
  endtask

  task automatic tok(input logic [1:0] k);
    tokValid = 1; tokKind = k; tick();
  endtask

  task automatic pkt(input logic [3:0] e);
    pktEnd = 1; {crcErr, stuffErr, fifoOvr, fifoUnd} = e; tick();
  endtask

  task automatic fw(input logic [4:0] d, input logic sv);
    regWrEn = 1; regWrData = d; seqWrVal = sv; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    curReq = "R1";
    chk({regRdData, rxToggle, rxIrq, hsAck}, 8'b00000_000, "R1 reset state");
    chk({7'd0, fifoFreeze}, 8'd0, "R1 freeze at reset");

    curReq = "R3";
    tok(2'b00); pkt(4'b0000);
    chk({regRdData, rxToggle, rxIrq, hsAck}, 8'b00001_111, "R3 clean OUT");

    curReq = "R4";
    for (int i = 0; i < 4; i++) begin
      tok(2'b00); pkt(4'b1000 >> i);
      chk({regRdData, rxToggle, rxIrq, hsAck}, 8'b00010_110, "R4 error flag");
    end

    curReq = "R11";
    irqClr = 1; tick();
    chk({7'd0, rxIrq}, 8'd0, "R11 irq clear");

    curReq = "R5";
    cfgStall = 1; tok(2'b00); pkt(4'b0000); cfgStall = 0;
    chk({regRdData, rxToggle, rxIrq, hsAck}, 8'b00110_100, "R5 stall void");

    curReq = "R6";
    cfgCtrl = 1; tok(2'b01);
    chk({7'd0, rxToggle}, 8'd0, "R6 SETUP forces toggle 0");
    pkt(4'b0000);
    chk({regRdData, rxToggle, rxIrq, hsAck}, 8'b10001_111, "R6 SETUP locks");
    chk({7'd0, fifoFreeze}, 8'd1, "R6 freeze out");

    curReq = "R5";
    tok(2'b00); pkt(4'b0000);
    chk({regRdData, rxToggle, hsAck}, 7'b10101_10, "R5 locked void");

    curReq = "R7";
    fw(5'b00000, 0);
    chk({3'd0, regRdData}, 8'b10101, "R7 write 0 keeps lock");
    fw(5'b10000, 0);
    chk({3'd0, regRdData}, 8'b00101, "R7 write 1 clears lock");

    curReq = "R8";
    fw(5'b01000, 0);
    chk({regRdData, rxToggle, 2'b00}, 8'b00101_000, "R8 toggle load, R2 bit3 reads 0");
    fw(5'b00000, 1);
    chk({7'd0, rxToggle}, 8'd0, "R8 bit3 zero no load");

    curReq = "R7";
    tok(2'b01);
    pktEnd = 1; regWrEn = 1; regWrData = 5'b10000; tick();
    chk({regRdData, rxToggle, 2'b00}, 8'b10001_100, "R7 set wins over clear");
    fw(5'b10000, 0);
    chk({3'd0, regRdData}, 8'b00001, "R7 clear after collision");

    curReq = "R8";
    tok(2'b00);
    pktEnd = 1; regWrEn = 1; regWrData = 5'b01000; seqWrVal = 0; tick();
    chk({regRdData, rxToggle, 1'b0, hsAck}, 8'b00001_001, "R8 load wins over flip");

    curReq = "R6";
    cfgCtrl = 0; tok(2'b01); pkt(4'b0000);
    chk({regRdData, rxToggle, fifoFreeze, hsAck}, 8'b00001_101, "R6 non-control no lock");

    curReq = "R9";
    irqClr = 1; tick();
    cfgIso = 1; tok(2'b00); pkt(4'b1000);
    chk({regRdData, rxToggle, rxIrq, hsAck}, 8'b00001_100, "R9 iso held");
    tok(2'b10);
    chk({regRdData, rxToggle, rxIrq, hsAck}, 8'b00010_110, "R9 posted at SOF");

    curReq = "R10";
    irqClr = 1; tick();
    tok(2'b00); pkt(4'b1000); tok(2'b00); pkt(4'b0000);
    chk({3'd0, regRdData}, 8'b00010, "R10 nothing before SOF");
    tok(2'b10);
    chk({regRdData, rxToggle, rxIrq, hsAck}, 8'b00001_110, "R10 newer outcome wins");
    irqClr = 1; tick();
    tok(2'b10);
    chk({regRdData, rxToggle, rxIrq, hsAck}, 8'b00001_100, "R10 empty SOF no change");

    curReq = "R12";
    cfgIso = 0; pkt(4'b1000);
    chk({regRdData, rxToggle, rxIrq, hsAck}, 8'b00001_100, "R12 stray pktEnd ignored");
    tok(2'b11); pkt(4'b1000);
    chk({regRdData, rxToggle, rxIrq, hsAck}, 8'b00001_100, "R12 reserved token ignored");

    curReq = "R11";
    tok(2'b00);
    pktEnd = 1; irqClr = 1; tick();
    chk({regRdData, rxToggle, rxIrq, hsAck}, 8'b00001_011, "R11 set wins over clear");

    repeat (2) tick();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule